// File: doc/BRIEF.md
# UART Status Flag and Interrupt Unit

This block keeps the status and interrupt flags of a UART in one place. The receiver and transmitter cores send it single-cycle event strobes: start bit accepted, reception finished, character received with its data, and break stop bit reached. The raw clear-to-send pin also comes in, along with set and clear strobes from the register interface and one interrupt enable per flag. Out come the five flag bits and one combined interrupt line.

The flags are character match, receive busy, clear-to-send level, clear-to-send change and pending break. The clear-to-send pin passes through a synchronizer. The level flag holds the inverse of the synchronized pin. The change flag records any toggle of the pin while flow control is switched on. A build parameter can remove flow-control support, and both clear-to-send flags then read 0.

Top module: `uart_stat_irq`

## Requirements
- R1: After reset every flag in `flags_o` is 0 and `irq_o` is 0.
- R2: Flag bit 0 (match) is 1 on the cycle after a cycle in which `rx_char_valid_i` is 1 and `rx_char_i` equals `match_value_i`.
- R3: Once set, match stays 1 until a cycle with `clr_match_i` = 1. If a match event and a clear come in the same cycle, the flag is 1 afterwards.
- R4: Flag bit 1 (busy) goes to 1 the cycle after `rx_start_i` and to 0 the cycle after `rx_end_i`. If both come in the same cycle, busy is 1 afterwards.
- R5: Flag bit 2 (CTS level) is the inverse of `cts_pin_i` as seen through a 2-flop synchronizer. A pin change applied before clock edge k shows after edge k+1. The reset value corresponds to the pin being high.
- R6: Flag bit 3 (CTS change) goes to 1 one edge after the CTS level flag changes, provided `flow_ctl_en_i` is 1 at that edge. It clears on `clr_cts_chg_i`. A toggle wins over a clear in the same cycle.
- R7: Flag bit 4 (break) goes to 1 after `brk_req_i` and to 0 after `tx_brk_stop_i`. If both come in the same cycle, the flag is 1 afterwards.
- R8: `irq_o` is 1 exactly when some bit of `flags_o & ie_i` is 1, using the bit positions given above.
- R9: With parameter `FLOW_CTL_EN` = 0, flag bits 2 and 3 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_start_i | input | 1 | Receiver accepted a start bit |
| rx_end_i | input | 1 | Reception ended, with or without success |
| rx_char_valid_i | input | 1 | Received character is valid |
| rx_char_i | input | CHAR_W | Received character |
| match_value_i | input | CHAR_W | Programmed match value |
| tx_brk_stop_i | input | 1 | Transmitter is in the break frame stop bit |
| brk_req_i | input | 1 | Software break request |
| cts_pin_i | input | 1 | Raw clear-to-send pin |
| flow_ctl_en_i | input | 1 | CTS flow control enable |
| clr_match_i | input | 1 | Software clear of the match flag |
| clr_cts_chg_i | input | 1 | Software clear of the CTS change flag |
| ie_i | input | 5 | Per-flag interrupt enables |
| flags_o | output | 5 | Flag bits |
| irq_o | output | 1 | Combined interrupt |

## Verification
Random stimulus biases the received characters toward the match value. This makes the match equality show up both when it hits and when it barely misses. The clear strobes, start/end strobes and break strobes are random and often overlap, so the set-over-clear priority is tested many times. The CTS pin changes slowly and flow control toggles on and off, which separates synchronizer latency from edge gating. A second instance built without flow control shows whether the parameter really forces its CTS bits to 0.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int unsigned NFLAGS = 5;
  localparam int unsigned FLG_MATCH   = 0;
  localparam int unsigned FLG_BUSY    = 1;
  localparam int unsigned FLG_CTS_LVL = 2;
  localparam int unsigned FLG_CTS_CHG = 3;
  localparam int unsigned FLG_BRK     = 4;
endpackage

// File: rtl/uart_stat_flag.sv
module uart_stat_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/uart_cts_sync.sv
module uart_cts_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic sync_o,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // reset to 1: pin idle high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign sync_o = sync_q[STAGES-1];
  assign edge_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/uart_stat_irq.sv
module uart_stat_irq
  import uart_stat_pkg::*;
#(
  parameter int unsigned CHAR_W      = 8,
  parameter bit          FLOW_CTL_EN = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_start_i,
  input  logic              rx_end_i,
  input  logic              rx_char_valid_i,
  input  logic [CHAR_W-1:0] rx_char_i,
  input  logic [CHAR_W-1:0] match_value_i,
  input  logic              tx_brk_stop_i,
  input  logic              brk_req_i,
  input  logic              cts_pin_i,
  input  logic              flow_ctl_en_i,
  input  logic              clr_match_i,
  input  logic              clr_cts_chg_i,
  input  logic [NFLAGS-1:0] ie_i,
  output logic [NFLAGS-1:0] flags_o,
  output logic              irq_o
);
  logic match_hit;
  assign match_hit = rx_char_valid_i && (rx_char_i == match_value_i);

  uart_stat_flag i_match (
    .clk_i, .rst_ni, .set_i(match_hit), .clr_i(clr_match_i),
    .flag_o(flags_o[FLG_MATCH])
  );

  uart_stat_flag i_busy (
    .clk_i, .rst_ni, .set_i(rx_start_i), .clr_i(rx_end_i),
    .flag_o(flags_o[FLG_BUSY])
  );

  uart_stat_flag i_brk (
    .clk_i, .rst_ni, .set_i(brk_req_i), .clr_i(tx_brk_stop_i),
    .flag_o(flags_o[FLG_BRK])
  );

  if (FLOW_CTL_EN) begin : g_fc
    logic cts_sync, cts_edge;
    uart_cts_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i, .rst_ni, .pin_i(cts_pin_i), .sync_o(cts_sync), .edge_o(cts_edge)
    );
    assign flags_o[FLG_CTS_LVL] = ~cts_sync;
    uart_stat_flag i_chg (
      .clk_i, .rst_ni, .set_i(cts_edge & flow_ctl_en_i), .clr_i(clr_cts_chg_i),
      .flag_o(flags_o[FLG_CTS_CHG])
    );
  end else begin : g_nofc
    logic unused_fc;
    assign unused_fc = ^{cts_pin_i, flow_ctl_en_i, clr_cts_chg_i};
    assign flags_o[FLG_CTS_LVL] = 1'b0;
    assign flags_o[FLG_CTS_CHG] = 1'b0;
  end

  assign irq_o = |(flags_o & ie_i);
endmodule

// File: rtl/uart_stat_irq_chk.sv
module uart_stat_irq_chk
  import uart_stat_pkg::*;
#(
  parameter int unsigned CHAR_W      = 8,
  parameter bit          FLOW_CTL_EN = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_start_i,
  input logic              rx_end_i,
  input logic              rx_char_valid_i,
  input logic [CHAR_W-1:0] rx_char_i,
  input logic [CHAR_W-1:0] match_value_i,
  input logic              tx_brk_stop_i,
  input logic              brk_req_i,
  input logic              flow_ctl_en_i,
  input logic              clr_match_i,
  input logic [NFLAGS-1:0] ie_i,
  input logic [NFLAGS-1:0] flags_o,
  input logic              irq_o
);
  assert_match_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_char_valid_i && rx_char_i == match_value_i) |=> flags_o[FLG_MATCH]);

  assert_match_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[FLG_MATCH] && !clr_match_i) |=> flags_o[FLG_MATCH]);

  assert_busy_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_start_i |=> flags_o[FLG_BUSY]);

  assert_busy_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_end_i && !rx_start_i) |=> !flags_o[FLG_BUSY]);

  assert_chg_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flags_o[FLG_CTS_CHG] && !flow_ctl_en_i) |=> !flags_o[FLG_CTS_CHG]);

  assert_brk_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_req_i |=> flags_o[FLG_BRK]);

  assert_brk_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_brk_stop_i && !brk_req_i) |=> !flags_o[FLG_BRK]);

  assert_irq_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((flags_o & ie_i) != '0));

  assert_nofc_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !FLOW_CTL_EN |-> (flags_o[FLG_CTS_LVL] == 1'b0 && flags_o[FLG_CTS_CHG] == 1'b0));
endmodule

bind uart_stat_irq uart_stat_irq_chk #(.CHAR_W(CHAR_W), .FLOW_CTL_EN(FLOW_CTL_EN)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_start_i(rx_start_i), .rx_end_i(rx_end_i),
  .rx_char_valid_i(rx_char_valid_i), .rx_char_i(rx_char_i),
  .match_value_i(match_value_i), .tx_brk_stop_i(tx_brk_stop_i),
  .brk_req_i(brk_req_i), .flow_ctl_en_i(flow_ctl_en_i),
  .clr_match_i(clr_match_i), .ie_i(ie_i), .flags_o(flags_o), .irq_o(irq_o)
);

// File: tb/test_uart_stat_irq.sv
module test_uart_stat_irq;
  localparam int unsigned W = 8;
  localparam int unsigned NF = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_start, rx_end, rx_cv, brk_stop, brk_req, cts_pin, fc_en, clr_m, clr_c;
  logic [W-1:0] rx_char, mval;
  logic [NF-1:0] ie, flags, flags_nf;
  logic irq, irq_nf;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  logic m_match, m_busy, m_chg, m_brk, s0, s1, q;

  always #2.5 clk = ~clk;

  uart_stat_irq i_uart_stat_irq (
    .clk_i(clk), .rst_ni(rst_n), .rx_start_i(rx_start), .rx_end_i(rx_end),
    .rx_char_valid_i(rx_cv), .rx_char_i(rx_char), .match_value_i(mval),
    .tx_brk_stop_i(brk_stop), .brk_req_i(brk_req), .cts_pin_i(cts_pin),
    .flow_ctl_en_i(fc_en), .clr_match_i(clr_m), .clr_cts_chg_i(clr_c),
    .ie_i(ie), .flags_o(flags), .irq_o(irq)
  );

  uart_stat_irq #(.FLOW_CTL_EN(1'b0)) i_uart_stat_irq_nofc (
    .clk_i(clk), .rst_ni(rst_n), .rx_start_i(rx_start), .rx_end_i(rx_end),
    .rx_char_valid_i(rx_cv), .rx_char_i(rx_char), .match_value_i(mval),
    .tx_brk_stop_i(brk_stop), .brk_req_i(brk_req), .cts_pin_i(cts_pin),
    .flow_ctl_en_i(fc_en), .clr_match_i(clr_m), .clr_cts_chg_i(clr_c),
    .ie_i(ie), .flags_o(flags_nf), .irq_o(irq_nf)
  );

  function automatic logic [NF-1:0] exp_flags();
    return {m_brk, m_chg, ~s1, m_busy, m_match};
  endfunction

  task automatic chk(input string req, input logic [NF-1:0] act, input logic [NF-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    rx_start = 0; rx_end = 0; rx_cv = 0; brk_stop = 0; brk_req = 0;
    clr_m = 0; clr_c = 0; rx_char = '0;
  endtask

  // one clock: update model from driven inputs, then compare
  task automatic step();
    logic set_c;
    @(posedge clk);
    set_c  = fc_en && (s1 != q);
    m_match = (rx_cv && rx_char == mval) ? 1'b1 : (clr_m ? 1'b0 : m_match);
    m_busy  = rx_start ? 1'b1 : (rx_end ? 1'b0 : m_busy);
    m_brk   = brk_req ? 1'b1 : (brk_stop ? 1'b0 : m_brk);
    m_chg   = set_c ? 1'b1 : (clr_c ? 1'b0 : m_chg);
    q = s1; s1 = s0; s0 = cts_pin;
    #1;
    chk("R2/R3/R4/R5/R6/R7 flags", flags, exp_flags());
    chk("R8 irq", {4'b0, irq}, {4'b0, |(exp_flags() & ie)});
    chk("R9 nofc cts bits", flags_nf[3:2], 2'b00);
    chk("R9 nofc others", {flags_nf[4], flags_nf[1:0]}, {m_brk, m_busy, m_match});
    @(negedge clk);
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    idle_inputs();
    cts_pin = 1; fc_en = 1; mval = 8'h5a; ie = '1;
    m_match = 0; m_busy = 0; m_chg = 0; m_brk = 0; s0 = 1; s1 = 1; q = 1;
    #12;
    // R1
    chk("R1 reset flags", flags, '0);
    chk("R1 reset irq", {4'b0, irq}, '0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    // R3 set wins over clear
    rx_cv = 1; rx_char = 8'h5a; clr_m = 1; step();
    idle_inputs(); step();
    chk("R3 match held", {4'b0, flags[0]}, 5'b1);
    clr_m = 1; step(); idle_inputs();
    chk("R3 match cleared", {4'b0, flags[0]}, 5'b0);
    // R2 near miss
    rx_cv = 1; rx_char = 8'h5b; step(); idle_inputs();
    chk("R2 near miss", {4'b0, flags[0]}, 5'b0);
    // R4 start+end together
    rx_start = 1; rx_end = 1; step(); idle_inputs();
    chk("R4 start wins", {4'b0, flags[1]}, 5'b1);
    rx_end = 1; step(); idle_inputs();
    chk("R4 end clears", {4'b0, flags[1]}, 5'b0);
    // R7 request+stop together
    brk_req = 1; brk_stop = 1; step(); idle_inputs();
    chk("R7 req wins", {4'b0, flags[4]}, 5'b1);
    brk_stop = 1; step(); idle_inputs();
    chk("R7 stop clears", {4'b0, flags[4]}, 5'b0);
    // R5 latency and R6 gating
    cts_pin = 0; fc_en = 0; step();
    chk("R5 not yet", {4'b0, flags[2]}, 5'b0);
    step();
    chk("R5 inverted level", {4'b0, flags[2]}, 5'b1);
    step(); step();
    chk("R6 gated off", {4'b0, flags[3]}, 5'b0);
    fc_en = 1; cts_pin = 1; step(); step(); step();
    chk("R6 toggle sets", {4'b0, flags[3]}, 5'b1);
    clr_c = 1; step(); idle_inputs();
    chk("R6 cleared", {4'b0, flags[3]}, 5'b0);
    // R8 enable masking
    ie = '0; brk_req = 1; step(); idle_inputs();
    chk("R8 masked", {4'b0, irq}, 5'b0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      rx_start = ($urandom % 6) == 0;
      rx_end   = ($urandom % 6) == 0;
      rx_cv    = ($urandom % 3) == 0;
      rx_char  = ($urandom % 2) ? mval ^ W'(1 << ($urandom % W)) : mval;
      if (($urandom % 4) == 0) rx_char = W'($urandom);
      brk_req  = ($urandom % 8) == 0;
      brk_stop = ($urandom % 6) == 0;
      clr_m    = ($urandom % 4) == 0;
      clr_c    = ($urandom % 4) == 0;
      if (($urandom % 7) == 0) cts_pin = ~cts_pin;
      if (($urandom % 40) == 0) fc_en = ~fc_en;
      if (($urandom % 50) == 0) mval = W'($urandom);
      ie = NF'($urandom);
      step();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule